// File: doc/BRIEF.md
# Self-Timed Byte Programming Controller

This block sits between the serial slave engine of a small non-volatile byte store and the storage array itself. When the engine has received a complete byte-write sequence closed by STOP, it raises a one-cycle commit request carrying the target location and the byte. The controller latches both. It then runs a programming interval of fixed length, counted in system-clock cycles. At the end of that interval it replaces the stored byte, and it then drops `busy`.

While `busy` is high, the engine refuses to acknowledge every control byte. A bus master can therefore poll with write-mode control bytes until one is acknowledged. Each interval erases the location and writes the new value in one step, so the stored byte becomes the new value whatever bits it held before. A supply-low input vetoes a commit request outright, and the array is then left untouched. The array is read combinationally through a read port that the engine uses to serve reads.

Top module: `prog_cycle_ctrl`

## Requirements
- R1: After reset `busy` is 0 and every array location reads the erased value 8'hFF.
- R2: A commit request sampled while idle with `supply_low` at 0 is accepted, and `busy` is 1 in the next cycle.
- R3: An accepted commit keeps `busy` high for exactly WC_CYCLES+1 consecutive cycles.
- R4: The target location keeps its old value for the first WC_CYCLES busy cycles. It holds the new value in the last busy cycle, and `busy` falls in the cycle after that.
- R5: A programmed location takes the new byte in full, whatever its previous bits; a 1 may replace a 0. No other location changes.
- R6: A commit request sampled with `supply_low` at 1 is discarded: `busy` stays 0 and the array is unchanged. `supply_low` is looked at only when a request is accepted, so raising it during an interval does not stop that interval's write.
- R7: Commit requests sampled while `busy` is 1 are ignored. This includes the last busy cycle. They neither write the array nor extend the interval.
- R8: A commit request in the first cycle after `busy` falls is accepted.
- R9: `rd_data` always shows the current contents of the location selected by `rd_addr`.
- R10: The address and data written are those present on the cycle the request was accepted; later changes on `commit_addr` and `commit_data` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| commit_req | input | 1 | One-cycle request to program a byte |
| commit_addr | input | AW | Location to program |
| commit_data | input | DW | Byte to program |
| supply_low | input | 1 | Supply below the programming threshold; vetoes a commit |
| rd_addr | input | AW | Read location |
| rd_data | output | DW | Contents of the read location |
| busy | output | 1 | Programming interval in progress; the engine must not acknowledge |

## Verification
Two functions can share a cycle. The array update on the last interval edge can meet a new commit request, and the fall of `busy` can meet the next accepted commit. The bench drives a request exactly in the final busy cycle. It then expects `busy` low on the next cycle and the requested location still erased. In a separate case it drives a request in the first idle cycle and expects a fresh interval of the full length, whose stored byte the scoreboard checks against the queued item.

// File: rtl/prog_cycle_ctrl.sv
module prog_cycle_ctrl #(
  parameter int DEPTH     = 16,
  parameter int DW        = 8,
  parameter int WC_CYCLES = 200000,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(WC_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit_req,
  input  logic [AW-1:0] commit_addr,
  input  logic [DW-1:0] commit_data,
  input  logic          supply_low,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          busy
);

  typedef enum logic [1:0] {ST_IDLE, ST_PROG, ST_REL} st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic [AW-1:0] lat_addr;
  logic [DW-1:0] lat_data;
  logic [DW-1:0] mem [DEPTH];

  wire take = (state == ST_IDLE) && commit_req && !supply_low;
  wire last = (state == ST_PROG) && (cnt == CW'(WC_CYCLES - 1));

  assign busy    = (state != ST_IDLE);
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      lat_addr <= '0;
      lat_data <= '0;
    end else begin
      case (state)
        ST_IDLE: if (take) begin
          state    <= ST_PROG;
          cnt      <= '0;
          lat_addr <= commit_addr;
          lat_data <= commit_data;
        end
        ST_PROG: if (last) state <= ST_REL;
                 else      cnt   <= cnt + CW'(1);
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (last) begin
      mem[lat_addr] <= lat_data;
    end
  end

endmodule

// File: rtl/prog_cycle_chk.sv
module prog_cycle_chk #(
  parameter int AW        = 4,
  parameter int DW        = 8,
  parameter int WC_CYCLES = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          commit_req,
  input logic          supply_low,
  input logic [AW-1:0] rd_addr,
  input logic [DW-1:0] rd_data,
  input logic          busy
);

  int len;
  always_ff @(posedge clk) begin
    if (!rst_n) len <= 0;
    else        len <= busy ? len + 1 : 0;
  end

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && commit_req && !supply_low) |=> busy);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(commit_req && !supply_low)) |=> !busy);

  // R3
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (len == WC_CYCLES + 1));

  // R7
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (len <= WC_CYCLES));

  // R5
  quiet_array_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!busy) && $stable(rd_addr)) |-> $stable(rd_data));

endmodule

bind prog_cycle_ctrl prog_cycle_chk #(.AW(AW), .DW(DW), .WC_CYCLES(WC_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .commit_req(commit_req), .supply_low(supply_low),
  .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
);

// File: tb/prog_cycle_ctrl_bench.sv
module prog_cycle_ctrl_bench;
  localparam int WC = 10;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       commit_req = 0;
  logic [3:0] commit_addr = 0;
  logic [7:0] commit_data = 0;
  logic       supply_low = 0;
  logic [3:0] rd_addr = 0;
  logic [7:0] rd_data;
  logic       busy;

  int checks = 0;
  int errors = 0;
  logic [11:0] exp_q[$];
  logic [7:0]  model [16];

  always #10 clk = ~clk;

  prog_cycle_ctrl #(.DEPTH(16), .DW(8), .WC_CYCLES(WC)) u_prog_cycle_ctrl (
    .clk(clk), .rst_n(rst_n), .commit_req(commit_req), .commit_addr(commit_addr),
    .commit_data(commit_data), .supply_low(supply_low), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_rd(input logic [3:0] a, input logic [7:0] e, input string tag);
    rd_addr = a;
    #1;
    chk(rd_data === e, tag, rd_data, e);
  endtask

  task automatic commit(input logic [3:0] a, input logic [7:0] d, input bit sl,
                        input bit acc, input bit now);
    if (!now) @(negedge clk);
    commit_req = 1; commit_addr = a; commit_data = d; supply_low = sl;
    @(posedge clk);
    #1;
    commit_req = 0; supply_low = 0;
    commit_data = ~d; commit_addr = a + 4'd1;
    if (acc) begin
      rd_addr = a;
      model[a] = d;
      exp_q.push_back({a, d});
    end
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  // scoreboard monitor
  int  len = 0;
  bit  prev = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) len++;
      else if (prev) begin
        if (exp_q.size() == 0) chk(0, "R3 unexpected interval", len, 0);
        else begin
          logic [11:0] it;
          it = exp_q.pop_front();
          chk(len == WC + 1, "R3 busy length", len, WC + 1);
          chk(rd_data === it[7:0], "R10 stored byte", rd_data, it[7:0]);
        end
        len = 0;
      end
      prev = busy;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = 8'hFF;
    repeat (3) @(posedge clk);
    #1;
    chk(busy === 1'b0, "R1 busy after reset", busy, 0);
    rst_n = 1;
    for (int i = 0; i < 16; i++) chk_rd(4'(i), 8'hFF, "R1 erased");

    // R2 / R4 timing
    commit(4'd3, 8'h5A, 0, 1, 0);
    @(negedge clk);
    chk(busy === 1'b1, "R2 busy after accept", busy, 1);
    chk(rd_data === 8'hFF, "R4 old value first cycle", rd_data, 8'hFF);
    repeat (WC - 1) @(negedge clk);
    chk(rd_data === 8'hFF, "R4 old value before end", rd_data, 8'hFF);
    @(negedge clk);
    chk(rd_data === 8'h5A && busy === 1'b1, "R4 new value in last busy cycle",
        {busy, rd_data}, {1'b1, 8'h5A});
    wait_idle();

    // R7 mid-interval request
    commit(4'd4, 8'h44, 0, 1, 0);
    repeat (3) @(negedge clk);
    commit(4'd9, 8'h77, 0, 0, 1);
    wait_idle();
    chk_rd(4'd9, 8'hFF, "R7 mid request ignored");
    chk_rd(4'd4, 8'h44, "R7 active write intact");

    // R7 request in final busy cycle
    commit(4'd6, 8'h66, 0, 1, 0);
    repeat (WC + 1) @(negedge clk);
    commit(4'd10, 8'hAA, 0, 0, 1);
    @(negedge clk);
    chk(busy === 1'b0, "R7 no restart from final cycle", busy, 0);
    wait_idle();
    chk_rd(4'd10, 8'hFF, "R7 final-cycle request ignored");

    // R8 back-to-back
    commit(4'd2, 8'h33, 0, 1, 0);
    while (busy) @(negedge clk);
    commit(4'd1, 8'h11, 0, 1, 1);
    @(negedge clk);
    chk(busy === 1'b1, "R8 accept right after release", busy, 1);
    wait_idle();

    // R6 veto
    commit(4'd8, 8'h88, 1, 0, 0);
    @(negedge clk);
    chk(busy === 1'b0, "R6 veto keeps idle", busy, 0);
    repeat (WC + 4) @(negedge clk);
    chk_rd(4'd8, 8'hFF, "R6 vetoed location unchanged");

    // R6 supply low mid-interval does not stop write
    commit(4'd5, 8'h5C, 0, 1, 0);
    repeat (2) @(negedge clk);
    supply_low = 1;
    repeat (3) @(negedge clk);
    supply_low = 0;
    wait_idle();
    chk_rd(4'd5, 8'h5C, "R6 mid-interval supply low");

    // R5 full overwrite
    commit(4'd3, 8'h00, 0, 1, 0);
    wait_idle();
    commit(4'd3, 8'hA5, 0, 1, 0);
    wait_idle();
    chk_rd(4'd3, 8'hA5, "R5 ones over zeros");

    for (int i = 0; i < 16; i++) chk_rd(4'(i), model[i], "R9 final sweep");
    chk(exp_q.size() == 0, "R3 all intervals seen", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule